// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sits on the read side of a memory array and can serve reads in two ways. In asynchronous mode the word at the presented address is returned straight from the array with no clocking. In synchronous mode, a rising edge on the address-valid input latches a start address. The block then waits a programmed number of active clock edges and streams one word per active edge. The stream is either an endless linear count or a wrap-around burst of 8, 16 or 32 words. A ready output tells the consumer when a word is on the bus, or warns it one edge early.

An eight-bit settings word is loaded by a single-cycle strobe on the rising system clock. Its fields are: bit 7 selects asynchronous (1) or synchronous (0) reading. Bit 6 selects ready with data (1) or ready one edge early (0). Bit 5 selects the rising (1) or falling (0) clock edge as the active edge. Bits 4:3 choose the burst kind. Bits 2:0 set the initial latency. The output side behaves like a stream source with valid (`rd_valid`) and `rdy`, but it has no back-pressure: the consumer cannot stall a burst and must take one word per active edge while `rd_valid` is high. Dropping the chip enable is the only way to stop a burst.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the settings word is 8'hE5: asynchronous mode, ready with data, rising active edge, continuous bursts, latency code 3'b101.
- R2: When `cfg_load` is high at a rising `clk` edge, the settings word takes the value of `cfg_bits` (bit 7 mode, bit 6 ready timing, bit 5 edge, bits 4:3 burst kind, bits 2:0 latency).
- R3: In asynchronous mode `rd_addr` equals `addr_in`, `rd_valid` and `rdy` both equal `ce`, and no edge counting takes place.
- R4: In synchronous mode, active edge 1 is the first active edge at which `avd` is sampled high after being low while `ce` is high. For latency code c from 0 to 5, `rd_valid` first goes high after active edge c+2 and stays low before it, with `rd_addr` showing the start address on that first beat.
- R5: Latency codes 6 and 7 behave like code 5, with the first beat after active edge 7.
- R6: Burst kind 2'b00 (continuous) advances the whole address by one per active edge, rolling over from all ones to zero.
- R7: Burst kinds 2'b01, 2'b10 and 2'b11 advance the low 3, 4 or 5 address bits modulo 8, 16 or 32 and keep the upper bits fixed, starting from the latched word and not from the aligned block start.
- R8: With ready-with-data timing, `rdy` is high exactly on the active edges where `rd_valid` is high.
- R9: With early timing, `rdy` goes high one active edge before `rd_valid` first rises and stays high for the whole burst.
- R10: With the falling edge selected, the sequencer state and its outputs change on falling `clk` edges only.
- R11: `ce` low at an active edge returns the sequencer to idle, with `rd_valid` and `rdy` low after it. This takes priority over a coincident `avd` rise, and a burst restarts only on a fresh low-to-high `avd` transition.
- R12: `rd_data` always equals the array word at `rd_addr`, and array words are written through `wr_en`, `wr_addr` and `wr_data` on rising `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the settings word |
| cfg_bits | input | 8 | Settings value to load |
| ce | input | 1 | Chip enable; low ends any burst |
| avd | input | 1 | Address-valid strobe; a rising transition starts a burst |
| addr_in | input | AW | Start or asynchronous word address |
| wr_en | input | 1 | Array write enable |
| wr_addr | input | AW | Array write address |
| wr_data | input | DW | Array write data |
| rd_addr | output | AW | Address of the current word |
| rd_data | output | DW | Array word at `rd_addr` |
| rd_valid | output | 1 | Current word valid |
| rdy | output | 1 | Ready indication (with data or one edge early) |

## Verification
A chip-enable drop and a new address-valid rise can reach the sequencer on the same active edge. The two would send the sequencer to opposite places: idle, or a new latency wait. The bench provokes this in the middle of a running burst by lowering `ce` and raising `avd` in the same half period. It then expects idle output after that edge. With `avd` held high and `ce` back high, the output must stay idle, because the high level alone is not a fresh transition. Only a later low-to-high transition may start a burst, which must then show its first beat after the programmed latency.

// File: rtl/burst_read_pkg.sv
package burst_read_pkg;

  typedef struct packed {
    logic       async_mode;
    logic       rdy_with;
    logic       edge_rise;
    logic [1:0] blen;
    logic [2:0] lat;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_DEFAULT = '{
    async_mode: 1'b1, rdy_with: 1'b1, edge_rise: 1'b1, blen: 2'b00, lat: 3'b101
  };

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BURST} seq_state_t;

  // Number of active edges from the start edge to the first beat.
  function automatic logic [3:0] lat_edges(input logic [2:0] code);
    return (code > 3'd5) ? 4'd7 : ({1'b0, code} + 4'd2);
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_read_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] bits_in,
  output burst_cfg_t cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg <= CFG_DEFAULT;
    else if (load) cfg <= burst_cfg_t'(bits_in);
  end

  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg == burst_cfg_t'($past(bits_in))));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg));

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    blen,
  output logic [AW-1:0] nxt
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] inc;
  logic [AW-1:0] low_mask;

  assign inc = cur + ONE;

  always_comb begin
    low_mask = '1;
    if (blen != 2'b00) low_mask = (ONE << ({1'b0, blen} + 3'd2)) - ONE;
    nxt = (cur & ~low_mask) | (inc & low_mask);
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_read_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          seq_clk,
  input  logic          rst_n,
  input  burst_cfg_t    cfg,
  input  logic          ce,
  input  logic          avd,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q,
  output logic          valid_q,
  output logic          rdy_early_q
);

  localparam int CW = 3;
  localparam logic [AW-1:0] ONE = AW'(1);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          avd_q;
  logic          rise;
  logic [AW-1:0] step_addr;
  logic [3:0]    n_edges;

  assign rise    = avd && !avd_q;
  assign n_edges = lat_edges(cfg.lat);

  burst_addr_step #(.AW(AW)) step_i (
    .cur  (addr_q),
    .blen (cfg.blen),
    .nxt  (step_addr)
  );

  always_ff @(posedge seq_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      avd_q       <= 1'b0;
      addr_q      <= '0;
      valid_q     <= 1'b0;
      rdy_early_q <= 1'b0;
    end else begin
      avd_q <= avd;
      if (cfg.async_mode || !ce) begin
        state_q     <= S_IDLE;
        valid_q     <= 1'b0;
        rdy_early_q <= 1'b0;
      end else if (rise) begin
        state_q     <= S_WAIT;
        addr_q      <= addr_in;
        cnt_q       <= CW'(n_edges - 4'd1);
        valid_q     <= 1'b0;
        rdy_early_q <= (n_edges == 4'd2);
      end else begin
        unique case (state_q)
          S_WAIT: begin
            if (cnt_q == CW'(1)) begin
              state_q     <= S_BURST;
              valid_q     <= 1'b1;
              rdy_early_q <= 1'b1;
            end else begin
              cnt_q       <= cnt_q - CW'(1);
              rdy_early_q <= (cnt_q == CW'(2));
            end
          end
          S_BURST: addr_q <= step_addr;
          default: ;
        endcase
      end
    end
  end

  logic [AW-1:0] hi_mask;
  assign hi_mask = (cfg.blen == 2'b00) ? '0
                 : ~((ONE << ({1'b0, cfg.blen} + 3'd2)) - ONE);

  // R4: a first beat is always preceded by the latency wait
  a_r4_from_wait: assert property (@(posedge seq_clk) disable iff (!rst_n)
    $rose(valid_q) |-> ($past(state_q) == S_WAIT));

  a_r6_cont_step: assert property (@(posedge seq_clk) disable iff (!rst_n)
    (state_q == S_BURST && ce && !cfg.async_mode && cfg.blen == 2'b00 && !rise)
      |=> (addr_q == $past(addr_q) + ONE));

  a_r7_upper_fixed: assert property (@(posedge seq_clk) disable iff (!rst_n)
    (state_q == S_BURST && ce && !cfg.async_mode && cfg.blen != 2'b00 && !rise)
      |=> ((addr_q & hi_mask) == ($past(addr_q) & hi_mask)));

  a_r9_early_lead: assert property (@(posedge seq_clk) disable iff (!rst_n)
    (rdy_early_q && !valid_q && ce && !cfg.async_mode && !rise) |=> valid_q);

  a_r11_ce_idle: assert property (@(posedge seq_clk) disable iff (!rst_n)
    !ce |=> (!valid_q && !rdy_early_q));

endmodule

// File: rtl/burst_array.sv
module burst_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_read_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [7:0]    cfg_bits,
  input  logic          ce,
  input  logic          avd,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rdy
);

  burst_cfg_t    cfg;
  logic          seq_clk;
  logic [AW-1:0] seq_addr;
  logic          seq_valid;
  logic          seq_rdy_early;

  burst_cfg_reg cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .bits_in (cfg_bits),
    .cfg     (cfg)
  );

  // Active edge choice: the sequencer sees a rising edge on the chosen clk edge.
  assign seq_clk = cfg.edge_rise ? clk : ~clk;

  burst_seq #(.AW(AW)) seq_i (
    .seq_clk     (seq_clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .ce          (ce),
    .avd         (avd),
    .addr_in     (addr_in),
    .addr_q      (seq_addr),
    .valid_q     (seq_valid),
    .rdy_early_q (seq_rdy_early)
  );

  assign rd_addr  = cfg.async_mode ? addr_in : seq_addr;
  assign rd_valid = cfg.async_mode ? ce      : seq_valid;
  assign rdy      = cfg.async_mode ? ce
                  : (cfg.rdy_with ? seq_valid : seq_rdy_early);

  burst_array #(.AW(AW), .DW(DW)) array_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  a_r3_async_follow: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.async_mode |-> (rd_valid == ce && rd_addr == addr_in));

  a_r8_rdy_with: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.async_mode && cfg.rdy_with) |-> (rdy == rd_valid));

endmodule

// File: tb/burst_read_seq_tb_top.sv
module burst_read_seq_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [7:0]    cfg_bits = '0;
  logic          ce = 1'b0;
  logic          avd = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          rdy;

  int total = 0;
  int bad = 0;
  bit falling = 1'b0;

  always #5 clk = ~clk;

  burst_read_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bits(cfg_bits),
    .ce(ce), .avd(avd), .addr_in(addr_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .rdy(rdy)
  );

  // {settings, start address, beats}
  localparam logic [23:0] VEC [10] = '{
    {8'h60, 8'hFE, 8'd4}, {8'h69, 8'h15, 8'd10}, {8'h32, 8'h3B, 8'd20},
    {8'h5B, 8'h7E, 8'd34}, {8'h04, 8'h10, 8'd3}, {8'h2D, 8'h07, 8'd9},
    {8'h76, 8'h40, 8'd5}, {8'h1F, 8'h9F, 8'd3}, {8'h38, 8'hE3, 8'd4},
    {8'h45, 8'hFF, 8'd3}
  };

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {~a, a ^ 8'h3C};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int start, input int bl, input int k);
    int len;
    if (bl == 0) return AW'(start + k);
    len = 1 << (bl + 2);
    return AW'((start & ~(len - 1)) | ((start + k) & (len - 1)));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic act_edge();
    if (falling) @(negedge clk); else @(posedge clk);
    #2;
  endtask

  task automatic load_cfg(input logic [7:0] c);
    @(negedge clk);
    cfg_bits = c;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    falling = !c[5];
  endtask

  task automatic run_burst(input logic [7:0] c, input logic [7:0] start, input int beats);
    int n;
    bit early;
    logic [AW-1:0] ea;
    ce = 1'b0;
    avd = 1'b0;
    load_cfg(c);
    n = (c[2:0] > 3'd5) ? 7 : int'(c[2:0]) + 2;
    early = !c[6];
    act_edge();
    ce = 1'b1;
    addr_in = start;
    avd = 1'b1;
    for (int e = 1; e < n + beats; e++) begin
      act_edge();
      if (e < n) begin
        chk(rd_valid == 1'b0, c[2:0] > 3'd5 ? "R5 wait" : "R4 wait", rd_valid, 0);
        if (early) chk(rdy == (e == n - 1), "R9 early rdy", rdy, int'(e == n - 1));
        else       chk(rdy == 1'b0, "R8 rdy low", rdy, 0);
      end else begin
        ea = exp_addr(start, int'(c[4:3]), e - n);
        chk(rd_valid == 1'b1, "R4 beat valid", rd_valid, 1);
        chk(rd_addr == ea, c[4:3] == 2'b00 ? "R6 addr" : "R7 addr", rd_addr, ea);
        chk(rd_data == pat(ea), "R12 data", rd_data, pat(ea));
        chk(rdy == 1'b1, early ? "R9 rdy held" : "R8 rdy with", rdy, 1);
      end
    end
    ce = 1'b0;
    avd = 1'b0;
    act_edge();
    chk(rd_valid == 1'b0 && rdy == 1'b0, "R11 ce end", {rd_valid, rdy}, 0);
  endtask

  initial begin
    #1ms;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // fill the array (R12)
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = AW'(a);
      wr_data = pat(AW'(a));
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R1 / R3: default is asynchronous pass-through
    #1;
    chk(rd_valid == 1'b0 && rdy == 1'b0, "R3 ce low", {rd_valid, rdy}, 0);
    addr_in = 8'h33;
    ce = 1'b1;
    #1;
    chk(rd_addr == 8'h33, "R1 R3 addr", rd_addr, 8'h33);
    chk(rd_valid && rdy, "R3 valid", {rd_valid, rdy}, 3);
    chk(rd_data == pat(8'h33), "R12 async data", rd_data, pat(8'h33));
    avd = 1'b1;
    repeat (9) @(posedge clk);
    #2;
    chk(rd_valid && rd_addr == 8'h33, "R3 no count", rd_addr, 8'h33);
    ce = 1'b0;
    avd = 1'b0;

    // R1: defaults other than mode (latency 7, with data, rising, continuous)
    run_burst(8'h65, 8'hA0, 3);

    // vector table walk
    for (int i = 0; i < 10; i++)
      run_burst(VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]));

    // every latency code x burst kind x ready timing (R4 R5 R8 R9 R10)
    for (int lat = 0; lat < 8; lat++)
      for (int bl = 0; bl < 4; bl++)
        for (int rw = 0; rw < 2; rw++)
          run_burst({1'b0, 1'(rw), 1'(lat & 1), 2'(bl), 3'(lat)}, 8'(8 * lat + 5 * bl + 6), 3);

    // R10: falling edge mode changes nothing on rising edges
    load_cfg(8'h40);
    act_edge();
    ce = 1'b1; addr_in = 8'h11; avd = 1'b1;
    act_edge();
    act_edge();
    chk(rd_valid == 1'b1, "R10 fall beat", rd_valid, 1);
    @(posedge clk); #2;
    chk(rd_addr == 8'h11, "R10 still on rising", rd_addr, 8'h11);
    @(negedge clk); #2;
    chk(rd_addr == 8'h12, "R10 step on falling", rd_addr, 8'h12);
    ce = 1'b0; avd = 1'b0;
    act_edge();

    // R11 collision: ce drop with a new avd rise on the same edge
    load_cfg(8'h60);
    act_edge();
    ce = 1'b1; addr_in = 8'h20; avd = 1'b1;
    act_edge();
    act_edge();
    chk(rd_addr == 8'h20 && rd_valid, "R4 lat0 first", rd_addr, 8'h20);
    avd = 1'b0;
    act_edge();
    ce = 1'b0; avd = 1'b1; addr_in = 8'h70;
    act_edge();
    chk(rd_valid == 1'b0 && rdy == 1'b0, "R11 ce wins", {rd_valid, rdy}, 0);
    ce = 1'b1;
    act_edge();
    act_edge();
    act_edge();
    chk(rd_valid == 1'b0, "R11 no fresh rise", rd_valid, 0);
    avd = 1'b0; addr_in = 8'h50;
    act_edge();
    avd = 1'b1;
    act_edge();
    chk(rd_valid == 1'b0, "R4 restart wait", rd_valid, 0);
    act_edge();
    chk(rd_valid && rd_addr == 8'h50, "R4 restart beat", rd_addr, 8'h50);
    ce = 1'b0; avd = 1'b0;

    // R1: reset restores asynchronous defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    falling = 1'b0;
    addr_in = 8'h9A;
    ce = 1'b1;
    #1;
    chk(rd_valid && rd_addr == 8'h9A, "R1 reset async", rd_addr, 8'h9A);
    ce = 1'b0;
    #1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule